// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Sequencer

This block moves 16-bit words between a host and a three-wire serial EEPROM that is driven by chip select, serial clock, a data line into the device and a data line out of it. The host gives one request: a direction, a starting word offset and a word count. The block checks the request against the device size. It then runs the whole command sequence on the serial lines without further help from the host.

A read sends its own full transaction for every word: chip select, read opcode, word address, sixteen clocks that shift data in, and then a return to standby. A write starts by sending the erase/write-enable command. It then sends one write transaction per word. After each word it holds chip select high and polls the device's ready level at a fixed spacing. When every word is done it sends the disable command. If a word never becomes ready within the poll budget, the run stops early with an error.

The host sees `busy` while a request runs. Each read word appears on a one-cycle `rd_valid` strobe. A write word is consumed with a `wr_take` strobe. At the end there is a one-cycle `done` pulse, and `err` is valid alongside it.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: A request is rejected when the offset is at or above 2^ADDR_BITS, when the count is zero, or when the count is larger than 2^ADDR_BITS minus the offset. A rejected request gives `done` with `err`=1 on the cycle after it is presented. Chip select is never raised for it.
- R2: Each read word is its own chip-select session. The session carries the read opcode (default 3'b110, OP_BITS wide), then the address offset+index (ADDR_BITS wide), then 16 data bits clocked in. The word is presented on `rd_data` with a one-cycle `rd_valid`. Words come out in ascending address order.
- R3: Between any two chip-select sessions, chip select stays low for at least one full serial clock period (2*HALF_DIV system cycles).
- R4: A write run first sends the enable command in one session. The command is OP_BITS+2 bits (default 5'b10011) followed by ADDR_BITS-2 zero bits. No word write comes before it.
- R5: Each written word is one session. The session carries the write opcode (default 3'b101), the word address and the 16 bits of `wr_data`. `wr_data` is captured in the cycle `wr_take` is raised, once per word.
- R6: After each word, chip select is raised again and the device's data output is sampled every POLL_GAP cycles. The word is complete on the first high sample. The next word does not start before that.
- R7: If POLL_MAX samples are all low, the run ends with `err`=1. The remaining words are not consumed or sent, and no disable command is sent.
- R8: After the last word is confirmed, the disable command is sent in one session. The command is OP_BITS+2 bits (default 5'b10000) followed by ADDR_BITS-2 zero bits. The run then ends with `err`=0.
- R9: All bits go out most significant first. The data line to the device changes only while the serial clock is low, and the serial clock is low whenever chip select is low.
- R10: `busy` is high from the accepted request until `done`. `done` lasts one cycle and `busy` is low during it. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when not busy |
| req_write | input | 1 | 1 = write run, 0 = read run |
| req_offset | input | ADDR_BITS+1 | First word offset |
| req_count | input | ADDR_BITS+1 | Number of words |
| wr_data | input | 16 | Word to be written next |
| wr_take | output | 1 | Pulse: `wr_data` was captured |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error status, valid with `done` |
| rd_valid | output | 1 | Pulse: `rd_data` holds a read word |
| rd_data | output | 16 | Read word |
| mw_cs | output | 1 | Device chip select |
| mw_sk | output | 1 | Device serial clock |
| mw_dout | output | 1 | Serial data toward the device |
| mw_din | input | 1 | Serial data / ready level from the device |

## Verification
The hardest case to reach is the poll timeout part-way through a multi-word write. The enable command and the first word must already have been accepted, and then the ready level must stay low for the whole poll budget. The bench's device model has a stuck-busy switch that holds its ready output low. A three-word write run with that switch set shows that only one word was taken, that no disable session followed, and that the second address kept its old contents. Rejection is covered at the exact size boundaries, next to an accepted run that reads the last four words of the device.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int MW_DATA_W = 16;
  localparam int MW_NB_W   = 5;

  typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_state_t;

  typedef enum logic [3:0] {
    Q_IDLE, Q_EN_OP, Q_EN_PAD, Q_EN_SB,
    Q_OP, Q_ADR, Q_DAT, Q_DAT_SB,
    Q_POLL, Q_POLL_SB, Q_DS_OP, Q_DS_PAD, Q_FIN_SB
  } seq_state_t;
endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_DIV - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/mw_shift.sv
module mw_shift
  import mw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 start,
  input  logic [MW_NB_W-1:0]   nbits,
  input  logic [MW_DATA_W-1:0] word,
  input  logic                 miso,
  output logic                 sk,
  output logic                 mosi,
  output logic                 fin,
  output logic [MW_DATA_W-1:0] rx
);
  sh_state_t             st;
  logic [MW_DATA_W-1:0]  shreg;
  logic [MW_NB_W-1:0]    left;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SH_IDLE;
      shreg <= '0;
      left  <= '0;
      sk    <= 1'b0;
      mosi  <= 1'b0;
      fin   <= 1'b0;
      rx    <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        SH_IDLE: if (start) begin
          shreg <= word << (5'd16 - nbits);
          left  <= nbits;
          rx    <= '0;
          st    <= SH_LOW;
        end
        SH_LOW: if (tick) begin
          sk <= 1'b0;
          if (left == '0) begin
            mosi <= 1'b0;
            fin  <= 1'b1;
            st   <= SH_IDLE;
          end else begin
            mosi  <= shreg[MW_DATA_W-1];
            shreg <= shreg << 1;
            left  <= left - 1'b1;
            st    <= SH_HIGH;
          end
        end
        SH_HIGH: if (tick) begin
          sk <= 1'b1;
          rx <= {rx[MW_DATA_W-2:0], miso};
          st <= SH_LOW;
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_bounds.sv
module mw_bounds #(
  parameter int ADDR_BITS = 6
) (
  input  logic [ADDR_BITS:0] offset,
  input  logic [ADDR_BITS:0] count,
  output logic               bad
);
  localparam int CW = ADDR_BITS + 1;
  localparam logic [CW:0] WORDS = (CW+1)'(1) << ADDR_BITS;

  logic [CW:0] room;

  always_comb begin
    room = WORDS - {1'b0, offset};
    bad  = ({1'b0, offset} >= WORDS) || (count == '0) || ({1'b0, count} > room);
  end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_BITS = 6,
  parameter int OP_BITS   = 3,
  parameter int HALF_DIV  = 4,
  parameter int POLL_GAP  = 16,
  parameter int POLL_MAX  = 200,
  parameter logic [OP_BITS-1:0] OP_READ  = 3'b110,
  parameter logic [OP_BITS-1:0] OP_WRITE = 3'b101,
  parameter logic [OP_BITS+1:0] OP_EWEN  = 5'b10011,
  parameter logic [OP_BITS+1:0] OP_EWDS  = 5'b10000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_BITS:0]   req_offset,
  input  logic [ADDR_BITS:0]   req_count,
  input  logic [MW_DATA_W-1:0] wr_data,
  output logic                 wr_take,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic                 rd_valid,
  output logic [MW_DATA_W-1:0] rd_data,
  output logic                 mw_cs,
  output logic                 mw_sk,
  output logic                 mw_dout,
  input  logic                 mw_din
);
  localparam int CW         = ADDR_BITS + 1;
  localparam int STBY_TICKS = 3;
  localparam int GW         = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam int PW         = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam logic [1:0]    SB_LAST  = 2'(STBY_TICKS - 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(POLL_GAP - 1);
  localparam logic [PW-1:0] PMX_LAST = PW'(POLL_MAX - 1);
  localparam logic [MW_NB_W-1:0] N_OP  = MW_NB_W'(OP_BITS);
  localparam logic [MW_NB_W-1:0] N_XOP = MW_NB_W'(OP_BITS + 2);
  localparam logic [MW_NB_W-1:0] N_AD  = MW_NB_W'(ADDR_BITS);
  localparam logic [MW_NB_W-1:0] N_PAD = MW_NB_W'(ADDR_BITS - 2);
  localparam logic [MW_NB_W-1:0] N_DAT = MW_NB_W'(MW_DATA_W);

  logic                 tick, eng_fin, bad;
  logic [MW_DATA_W-1:0] eng_rx;
  logic                 sh_start;
  logic [MW_NB_W-1:0]   sh_n;
  logic [MW_DATA_W-1:0] sh_word;

  seq_state_t           st;
  logic [ADDR_BITS-1:0] base, cur_addr;
  logic [CW-1:0]        idx, total;
  logic                 is_wr;
  logic [1:0]           sb_cnt;
  logic                 sb_last;
  logic [GW-1:0]        gap;
  logic [PW-1:0]        polls;

  mw_tick #(.HALF_DIV(HALF_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  mw_shift u_shift (
    .clk(clk), .rst(rst), .tick(tick), .start(sh_start), .nbits(sh_n),
    .word(sh_word), .miso(mw_din), .sk(mw_sk), .mosi(mw_dout),
    .fin(eng_fin), .rx(eng_rx)
  );

  mw_bounds #(.ADDR_BITS(ADDR_BITS)) u_bounds (
    .offset(req_offset), .count(req_count), .bad(bad)
  );

  assign cur_addr = base + idx[ADDR_BITS-1:0];
  assign sb_last  = tick && (sb_cnt == SB_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= Q_IDLE;
      base     <= '0;
      idx      <= '0;
      total    <= '0;
      is_wr    <= 1'b0;
      sb_cnt   <= '0;
      gap      <= '0;
      polls    <= '0;
      sh_start <= 1'b0;
      sh_n     <= '0;
      sh_word  <= '0;
      mw_cs    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      wr_take  <= 1'b0;
    end else begin
      sh_start <= 1'b0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      wr_take  <= 1'b0;
      if (tick && !sb_last) sb_cnt <= sb_cnt + 1'b1;
      case (st)
        Q_IDLE: if (req_valid) begin
          if (bad) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            busy     <= 1'b1;
            err      <= 1'b0;
            base     <= req_offset[ADDR_BITS-1:0];
            total    <= req_count;
            idx      <= '0;
            is_wr    <= req_write;
            mw_cs    <= 1'b1;
            sh_start <= 1'b1;
            if (req_write) begin
              sh_n    <= N_XOP;
              sh_word <= MW_DATA_W'(OP_EWEN);
              st      <= Q_EN_OP;
            end else begin
              sh_n    <= N_OP;
              sh_word <= MW_DATA_W'(OP_READ);
              st      <= Q_OP;
            end
          end
        end
        Q_EN_OP: if (eng_fin) begin
          sh_start <= 1'b1;
          sh_n     <= N_PAD;
          sh_word  <= '0;
          st       <= Q_EN_PAD;
        end
        Q_EN_PAD: if (eng_fin) begin
          mw_cs  <= 1'b0;
          sb_cnt <= '0;
          st     <= Q_EN_SB;
        end
        Q_EN_SB: if (sb_last) begin
          mw_cs    <= 1'b1;
          sh_start <= 1'b1;
          sh_n     <= N_OP;
          sh_word  <= MW_DATA_W'(OP_WRITE);
          st       <= Q_OP;
        end
        Q_OP: if (eng_fin) begin
          sh_start <= 1'b1;
          sh_n     <= N_AD;
          sh_word  <= MW_DATA_W'(cur_addr);
          st       <= Q_ADR;
        end
        Q_ADR: if (eng_fin) begin
          sh_start <= 1'b1;
          sh_n     <= N_DAT;
          sh_word  <= is_wr ? wr_data : '0;
          wr_take  <= is_wr;
          st       <= Q_DAT;
        end
        Q_DAT: if (eng_fin) begin
          mw_cs  <= 1'b0;
          sb_cnt <= '0;
          st     <= Q_DAT_SB;
          if (!is_wr) begin
            rd_valid <= 1'b1;
            rd_data  <= eng_rx;
            idx      <= idx + 1'b1;
          end
        end
        Q_DAT_SB: if (sb_last) begin
          if (is_wr) begin
            mw_cs <= 1'b1;
            gap   <= '0;
            polls <= '0;
            st    <= Q_POLL;
          end else if (idx == total) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= Q_IDLE;
          end else begin
            mw_cs    <= 1'b1;
            sh_start <= 1'b1;
            sh_n     <= N_OP;
            sh_word  <= MW_DATA_W'(OP_READ);
            st       <= Q_OP;
          end
        end
        Q_POLL: begin
          gap <= gap + 1'b1;
          if (gap == GAP_LAST) begin
            gap <= '0;
            if (mw_din) begin
              mw_cs  <= 1'b0;
              sb_cnt <= '0;
              idx    <= idx + 1'b1;
              st     <= Q_POLL_SB;
            end else if (polls == PMX_LAST) begin
              mw_cs  <= 1'b0;
              sb_cnt <= '0;
              err    <= 1'b1;
              st     <= Q_FIN_SB;
            end else begin
              polls <= polls + 1'b1;
            end
          end
        end
        Q_POLL_SB: if (sb_last) begin
          mw_cs    <= 1'b1;
          sh_start <= 1'b1;
          if (idx == total) begin
            sh_n    <= N_XOP;
            sh_word <= MW_DATA_W'(OP_EWDS);
            st      <= Q_DS_OP;
          end else begin
            sh_n    <= N_OP;
            sh_word <= MW_DATA_W'(OP_WRITE);
            st      <= Q_OP;
          end
        end
        Q_DS_OP: if (eng_fin) begin
          sh_start <= 1'b1;
          sh_n     <= N_PAD;
          sh_word  <= '0;
          st       <= Q_DS_PAD;
        end
        Q_DS_PAD: if (eng_fin) begin
          mw_cs  <= 1'b0;
          sb_cnt <= '0;
          st     <= Q_FIN_SB;
        end
        Q_FIN_SB: if (sb_last) begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= Q_IDLE;
        end
        default: st <= Q_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic cs,
  input logic sk,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic err,
  input logic rd_valid
);
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) low_run <= 16'hFFFF;
    else if (cs) low_run <= '0;
    else if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
  end

  // R9
  sk_quiet_chk: assert property (@(posedge clk) disable iff (rst) !cs |-> !sk);
  // R9
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sk && $past(sk)) |-> $stable(mosi));
  // R3
  stby_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs) |-> (low_run >= 16'(2 * HALF_DIV)));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R2
  rdv_busy_chk: assert property (@(posedge clk) disable iff (rst) rd_valid |-> busy);
  // R1
  reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err && !$past(busy)) |-> !cs);
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst(rst), .cs(mw_cs), .sk(mw_sk), .mosi(mw_dout),
  .busy(busy), .done(done), .err(err), .rd_valid(rd_valid)
);

// File: tb/mw_eeprom_ctrl_test.sv
module mw_eeprom_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADB = 6;
  localparam int OPB = 3;
  localparam int CMD = OPB + ADB;
  localparam int HALF = 4;
  localparam int GAP = 8;
  localparam int PMAX = 20;
  localparam int BUSYC = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADB:0] req_offset = '0, req_count = '0;
  logic [15:0] wr_data;
  logic wr_take, busy, done, err, rd_valid, mw_cs, mw_sk, mw_dout, mw_din;
  logic [15:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_ctrl #(.ADDR_BITS(ADB), .OP_BITS(OPB), .HALF_DIV(HALF),
    .POLL_GAP(GAP), .POLL_MAX(PMAX)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_count(req_count), .wr_data(wr_data),
    .wr_take(wr_take), .busy(busy), .done(done), .err(err),
    .rd_valid(rd_valid), .rd_data(rd_data), .mw_cs(mw_cs), .mw_sk(mw_sk),
    .mw_dout(mw_dout), .mw_din(mw_din));

  int vectors = 0, fails = 0;

  // ---------------- device model ----------------
  logic [15:0] mem [0:63];
  logic [15:0] golden [0:63];
  logic pcs = 0, psk = 0, rd_on = 0, rbit = 0, we = 0, stuck = 0, mdo = 0;
  logic [63:0] msh = '0;
  logic [ADB-1:0] raddr = '0;
  int nb = 0, busyc = 0, n_ewen = 0, n_ewds = 0, n_wr = 0, n_rd = 0, bad_cmd = 0;
  assign mw_din = mdo;

  always @(posedge clk) begin
    if (mw_cs && !pcs) begin nb = 0; msh = '0; rd_on = 0; end
    if (mw_cs && mw_sk && !psk) begin
      msh = {msh[62:0], mw_dout};
      nb++;
      if (nb == CMD && msh[CMD-1 -: OPB] == 3'b110) begin
        rd_on = 1; raddr = msh[ADB-1:0];
      end
    end
    if (mw_cs && !mw_sk && psk && rd_on && nb >= CMD && nb < CMD + 16)
      rbit = mem[raddr][15 - (nb - CMD)];
    if (!mw_cs && pcs) begin
      if (nb == CMD) begin
        if (msh[ADB-3:0] != '0) bad_cmd++;
        if (msh[CMD-1 -: OPB+2] == 5'b10011) begin we = 1; n_ewen++; end
        else if (msh[CMD-1 -: OPB+2] == 5'b10000) begin we = 0; n_ewds++; end
        else bad_cmd++;
      end else if (nb == CMD + 16) begin
        if (msh[CMD+15 -: OPB] == 3'b101) begin
          n_wr++;
          if (we) begin mem[msh[ADB+15 -: ADB]] = msh[15:0]; busyc = BUSYC; end
          else bad_cmd++;
        end else if (msh[CMD+15 -: OPB] == 3'b110) n_rd++;
        else bad_cmd++;
      end else if (nb != 0) bad_cmd++;
      rd_on = 0;
    end
    if (busyc > 0) busyc--;
    pcs = mw_cs; psk = mw_sk;
    mdo <= (nb == 0) ? ((busyc == 0) && !stuck) : rbit;
  end

  // ---------------- monitors ----------------
  logic [15:0] rdbuf [0:15];
  logic [15:0] wbuf [0:15];
  int rdn = 0, wtn = 0, csr = 0, donec = 0, lowrun = 1000, minlow = 1000, r9viol = 0;
  logic mpcs = 0, mpsk = 0, mpdo = 0;
  assign wr_data = wbuf[wtn[3:0]];

  always @(negedge clk) begin
    if (rd_valid) begin rdbuf[rdn[3:0]] = rd_data; rdn++; end
    if (wr_take) wtn++;
    if (done) donec++;
    if (mw_cs && !mpcs) begin csr++; if (lowrun < minlow) minlow = lowrun; end
    if (!mw_cs) lowrun++; else lowrun = 0;
    if (mw_sk && mpsk && mw_dout != mpdo) r9viol++;
    if (!mw_cs && mw_sk) r9viol++;
    mpcs = mw_cs; mpsk = mw_sk; mpdo = mw_dout;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start_req(input bit w, input int off, input int cnt);
    @(negedge clk);
    req_write = w; req_offset = (ADB+1)'(off); req_count = (ADB+1)'(cnt); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit e, output int cyc);
    cyc = 0;
    while (!done && cyc < 60000) begin @(negedge clk); cyc++; end
    e = err;
    if (!done) chk(0, "done never seen", 0, 1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!mw_cs && !mw_sk, "R9 lines idle after reset", {mw_cs, mw_sk}, 0);
    chk(!busy && !done, "R10 busy/done low after reset", {busy, done}, 0);
  endtask

  task automatic t_read(input int off, input int cnt);
    bit e; int cyc; int r0, n0, c0;
    r0 = rdn; n0 = n_rd; c0 = csr;
    start_req(0, off, cnt);
    wait_done(e, cyc);
    chk(!e, "R2 read run error flag", 32'(e), 0);
    chk(rdn - r0 == cnt, "R2 read word count", rdn - r0, cnt);
    chk(n_rd - n0 == cnt && csr - c0 == cnt, "R2 one session per word", csr - c0, cnt);
    for (int i = 0; i < cnt; i++)
      chk(rdbuf[(r0 + i) % 16] == golden[off + i], "R2 read data", rdbuf[(r0 + i) % 16], golden[off + i]);
  endtask

  task automatic t_reject(input int off, input int cnt);
    bit e; int cyc; int c0;
    c0 = csr;
    start_req(0, off, cnt);
    wait_done(e, cyc);
    chk(e && cyc == 0, "R1 reject reported next cycle", {e, cyc[30:0]}, 32'h80000000);
    repeat (20) @(negedge clk);
    chk(csr == c0, "R1 no chip select on reject", csr - c0, 0);
  endtask

  task automatic t_write(input int off);
    bit e; int cyc; int w0, e0, d0, b0;
    w0 = wtn; e0 = n_ewen; d0 = n_ewds; b0 = bad_cmd;
    for (int i = 0; i < 3; i++) wbuf[(w0 + i) % 16] = 16'hC3A0 + 16'(i * 16'h1111) + 16'(off);
    start_req(1, off, 3);
    wait_done(e, cyc);
    chk(!e, "R8 write run ends without error", 32'(e), 0);
    chk(wtn - w0 == 3, "R5 one capture per word", wtn - w0, 3);
    chk(n_ewen - e0 == 1 && bad_cmd == b0, "R4 enable before writes", n_ewen - e0, 1);
    chk(n_ewds - d0 == 1 && we == 0, "R8 disable sent at end", n_ewds - d0, 1);
    chk(cyc >= 3 * BUSYC, "R6 each word waited for ready", cyc, 3 * BUSYC);
    for (int i = 0; i < 3; i++) begin
      golden[off + i] = wbuf[(w0 + i) % 16];
      chk(mem[off + i] == golden[off + i], "R5 word stored in device", mem[off + i], golden[off + i]);
    end
    t_read(off, 3);
  endtask

  task automatic t_busy_ignore;
    bit e; int cyc; int r0, c0, d0, w0;
    r0 = rdn; c0 = csr; w0 = n_wr;
    start_req(0, 1, 1);
    repeat (20) @(negedge clk);
    start_req(1, 0, 1);
    wait_done(e, cyc);
    d0 = donec;
    repeat (800) @(negedge clk);
    chk(donec == d0 && csr - c0 == 1, "R10 request while busy ignored", csr - c0, 1);
    chk(n_wr == w0 && rdn - r0 == 1, "R10 no write from ignored request", n_wr - w0, 0);
    chk(rdbuf[r0 % 16] == golden[1], "R10 running read unaffected", rdbuf[r0 % 16], golden[1]);
  endtask

  task automatic t_timeout;
    bit e; int cyc; int w0, d0; logic [15:0] keep;
    keep = mem[21]; w0 = wtn; d0 = n_ewds;
    stuck = 1;
    for (int i = 0; i < 3; i++) wbuf[(w0 + i) % 16] = 16'h0F0F + 16'(i);
    start_req(1, 20, 3);
    wait_done(e, cyc);
    stuck = 0;
    chk(e, "R7 timeout reports error", 32'(e), 1);
    chk(wtn - w0 == 1, "R7 remaining words not taken", wtn - w0, 1);
    chk(n_ewds == d0, "R7 no disable after timeout", n_ewds - d0, 0);
    chk(mem[21] == keep, "R7 next address untouched", mem[21], keep);
    chk(cyc >= PMAX * GAP, "R6 full poll budget used", cyc, PMAX * GAP);
    golden[20] = mem[20];
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'h5A00 ^ 16'(i * 16'h0307);
      golden[i] = mem[i];
    end
    for (int i = 0; i < 16; i++) wbuf[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(5, 1);
    t_read(60, 4);
    t_reject(64, 1);
    t_reject(10, 0);
    t_reject(62, 3);
    t_write(10);
    t_busy_ignore();
    t_timeout();
    t_write(30);
    chk(minlow >= 2 * HALF, "R3 standby length", minlow, 2 * HALF);
    chk(r9viol == 0, "R9 data/clock discipline", r9viol, 0);
    chk(bad_cmd == 0, "R4 all sessions well formed", bad_cmd, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule